// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that runs on its own slow clock, separate from the bus clock used by software. Once software arms it with a start key, a 12-bit down-counter steps down at a rate set by an 8-bit prescaler. If the counter expires, the block raises a reset request for a fixed number of slow-clock cycles. It then reloads itself and keeps counting. Software keeps the system alive by writing a refresh key often enough. Nothing written over the bus can stop the watchdog after it has started; only a reset of the block stops it.

The divider select and the reload value are guarded. A write to either one lands only after an unlock key and while no earlier transfer of that field is still in flight. Any other key value locks them again. Each accepted value is carried into the slow domain by a toggle handshake. A busy flag for that field stays set until the slow side has taken the value. A debug-halt input holds the countdown, but only when the freeze configuration input is also set.

Top module: `wdg_timer`

## Requirements
- R1: After reset, the divider select reads 0, the reload value reads 0xFFF, the status reads 0 and `wdg_rst_req` is low. No reset request appears until the start key has been written.
- R2: Writing 0xCCCC to the key register starts the watchdog. Reset requests then recur every (reload+1) × divider slow-clock cycles. Writing any other key value afterwards does not stop them.
- R3: Each reset request holds `wdg_rst_req` high for exactly 4 consecutive slow-clock cycles.
- R4: Writing 0xAAAA to the key register reloads the down-counter and restarts the prescaler. Refreshing at intervals shorter than the timeout keeps any reset request from occurring.
- R5: Writes to the divider select and reload registers take effect only after 0x5555 has been written to the key register. Any other key value, 0xAAAA included, locks them again. Only bits [15:0] of a key write are compared, so 0xFFFF5555 also unlocks.
- R6: A divider select value p in 0..6 divides the slow clock by 4·2^p. The value 7 divides by 256, the same as 6.
- R7: Status bit 0 reports a divider-select transfer in flight and status bit 1 reports a reload transfer in flight. A bit reads 1 right after its write is accepted and clears once the slow domain holds the new value. A new reload value governs the countdown from the next reload onward.
- R8: A write to the divider select or reload register is ignored while that register's busy bit is set.
- R9: While `dbg_halt` and `dbg_freeze` are both high, the prescaler and the down-counter hold their values, which lengthens the timeout by exactly the frozen cycles. With `dbg_freeze` low, `dbg_halt` has no effect.
- R10: Register select 0 is the key register, which reads 0. Select 1 is the divider select in bits [2:0], select 2 is the reload value in bits [11:0] and select 3 is the status. Read data appears one bus cycle after `rd_sel` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data; a 16-bit write uses the low half |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 32 | Registered read data |
| slow_clk | input | 1 | Watchdog counting clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| dbg_halt | input | 1 | Debug halt indication |
| dbg_freeze | input | 1 | Freeze-on-halt configuration bit |
| wdg_rst_req | output | 1 | Reset request, registered in the slow domain |

## Verification
The countdown is checked by measuring the spacing between reset-request rises for several pairs of divider select and reload value. Divider selects 1, 3, 6 and 7 are tried with the same reload value, which separates a correct doubling from an off-by-one shift and shows that 7 saturates at 256. Key patterns are varied to tell the unlock, refresh, start and foreign keys apart. A pair of back-to-back reload writes shows that the busy gate drops the second write. One freeze window is run with the configuration bit set and one with it clear; the first must lengthen the period by exactly the window and the second must leave it unchanged.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  typedef enum logic [1:0] {
    SEL_KEY    = 2'd0,
    SEL_DIV    = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_STAT   = 2'd3
  } reg_sel_e;

  // cross-domain transfer channels
  localparam int XF_START   = 0;
  localparam int XF_REFRESH = 1;
  localparam int XF_DIV     = 2;
  localparam int XF_RELOAD  = 3;
  localparam int NUM_XFER   = 4;
endpackage

// File: rtl/wdg_xfer.sv
module wdg_xfer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_req,
  output logic src_busy,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_pulse
);
  localparam int MSB = SYNC_STAGES - 1;

  logic                   req_t;
  logic [SYNC_STAGES-1:0] fwd_sync;
  logic                   dst_seen;
  logic [SYNC_STAGES-1:0] ack_sync;

  // source side: flip the request level when idle
  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      req_t    <= 1'b0;
      ack_sync <= '0;
    end else begin
      if (src_req && !src_busy) req_t <= ~req_t;
      ack_sync <= {ack_sync[MSB-1:0], dst_seen};
    end
  end

  assign src_busy = req_t ^ ack_sync[MSB];

  // destination side: synchronize the level, emit one pulse per flip
  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      fwd_sync <= '0;
      dst_seen <= 1'b0;
    end else begin
      fwd_sync <= {fwd_sync[MSB-1:0], req_t};
      dst_seen <= fwd_sync[MSB];
    end
  end

  assign dst_pulse = fwd_sync[MSB] ^ dst_seen;

  AST_ONE_PULSE: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_pulse |=> !dst_pulse); // R7
  AST_BUSY_AFTER_REQ: assert property (@(posedge src_clk) disable iff (src_rst)
    (src_req && !src_busy) |=> src_busy); // R7
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PRE_W     = 8,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int MAX_SHIFT = PRE_W - BASE_LOG2;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] div_m1;

  always_comb begin
    if (int'(sel) >= MAX_SHIFT) div_m1 = '1;
    else                        div_m1 = PRE_W'((1 << (BASE_LOG2 + int'(sel))) - 1);
  end

  // >= lets a shrinking divider wrap at once instead of overflowing
  assign tick = en && (pre >= div_m1);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre <= '0;
    else if (en)     pre <= tick ? '0 : pre + 1'b1;
  end

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(pre)); // R9
endmodule

// File: rtl/wdg_downcnt.sv
module wdg_downcnt #(
  parameter int CNT_W     = 12,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             running,
  output logic             rst_req
);
  localparam int PCNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0]  cnt;
  logic [PCNT_W-1:0] pcnt;
  logic              fire;

  assign fire = tick && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else begin
      if (start) running <= 1'b1;
      if (load)      cnt <= reload;
      else if (tick) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      pcnt    <= '0;
    end else if (fire) begin
      rst_req <= 1'b1;
      pcnt    <= PCNT_W'(PULSE_LEN - 1);
    end else if (pcnt != '0) begin
      pcnt    <= pcnt - 1'b1;
    end else begin
      rst_req <= 1'b0;
    end
  end

  // checker: length of the current high stretch
  logic [7:0] chk_hi;
  always_ff @(posedge clk) begin
    if (rst)                          chk_hi <= '0;
    else if (!rst_req)                chk_hi <= '0;
    else if (chk_hi != 8'hFF)         chk_hi <= chk_hi + 1'b1;
  end

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    running |=> running); // R2
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !running |-> !rst_req); // R1
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    (!rst_req && chk_hi != 8'd0) |-> (chk_hi == 8'(PULSE_LEN))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt)); // R9
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 12,
  parameter int PRE_W       = 8,
  parameter int PR_W        = 3,
  parameter int PULSE_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              slow_clk,
  input  logic              slow_rst,
  input  logic              dbg_halt,
  input  logic              dbg_freeze,
  output logic              wdg_rst_req
);
  localparam logic [CNT_W-1:0] RL_RESET = '1;

  // ---------------- bus domain ----------------
  logic [KEY_W-1:0]    key;
  logic                key_wr;
  logic                unlocked;
  logic [PR_W-1:0]     pr_q;
  logic [CNT_W-1:0]    rl_q;
  logic [NUM_XFER-1:0] xreq, xbusy, xpulse;
  logic                unused_hi;

  assign key       = wr_data[KEY_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:KEY_W];
  assign key_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_KEY);

  always_comb begin
    xreq[XF_START]   = key_wr && (key == KEY_START)   && !xbusy[XF_START];
    xreq[XF_REFRESH] = key_wr && (key == KEY_REFRESH) && !xbusy[XF_REFRESH];
    xreq[XF_DIV]     = wr_en && (reg_sel_e'(wr_sel) == SEL_DIV)
                       && unlocked && !xbusy[XF_DIV];
    xreq[XF_RELOAD]  = wr_en && (reg_sel_e'(wr_sel) == SEL_RELOAD)
                       && unlocked && !xbusy[XF_RELOAD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      pr_q     <= '0;
      rl_q     <= RL_RESET;
    end else begin
      if (key_wr)          unlocked <= (key == KEY_UNLOCK);
      if (xreq[XF_DIV])    pr_q <= wr_data[PR_W-1:0];
      if (xreq[XF_RELOAD]) rl_q <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (reg_sel_e'(rd_sel))
        SEL_DIV:    rd_data <= DATA_W'(pr_q);
        SEL_RELOAD: rd_data <= DATA_W'(rl_q);
        SEL_STAT:   rd_data <= DATA_W'({xbusy[XF_RELOAD], xbusy[XF_DIV]});
        default:    rd_data <= '0;
      endcase
    end
  end

  // ---------------- crossings ----------------
  for (genvar g = 0; g < NUM_XFER; g++) begin : g_xfer
    wdg_xfer #(.SYNC_STAGES(SYNC_STAGES)) xfer_i (
      .src_clk  (clk),
      .src_rst  (rst),
      .src_req  (xreq[g]),
      .src_busy (xbusy[g]),
      .dst_clk  (slow_clk),
      .dst_rst  (slow_rst),
      .dst_pulse(xpulse[g])
    );
  end

  // ---------------- slow domain ----------------
  logic [SYNC_STAGES-1:0] halt_sync, frz_sync;
  logic                   frozen;
  logic [PR_W-1:0]        pr_s;
  logic [CNT_W-1:0]       rl_s;
  logic                   load, running, tick;

  always_ff @(posedge slow_clk) begin
    if (slow_rst) begin
      halt_sync <= '0;
      frz_sync  <= '0;
      pr_s      <= '0;
      rl_s      <= RL_RESET;
    end else begin
      halt_sync <= {halt_sync[SYNC_STAGES-2:0], dbg_halt};
      frz_sync  <= {frz_sync[SYNC_STAGES-2:0], dbg_freeze};
      if (xpulse[XF_DIV])    pr_s <= pr_q;
      if (xpulse[XF_RELOAD]) rl_s <= rl_q;
    end
  end

  assign frozen = halt_sync[SYNC_STAGES-1] && frz_sync[SYNC_STAGES-1];
  assign load   = xpulse[XF_START] || xpulse[XF_REFRESH];

  wdg_prescaler #(.PRE_W(PRE_W), .SEL_W(PR_W), .BASE_LOG2(2)) presc_i (
    .clk (slow_clk),
    .rst (slow_rst),
    .clr (load),
    .en  (running && !frozen),
    .sel (pr_s),
    .tick(tick)
  );

  wdg_downcnt #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) cnt_i (
    .clk    (slow_clk),
    .rst    (slow_rst),
    .start  (xpulse[XF_START]),
    .load   (load),
    .tick   (tick),
    .reload (rl_s),
    .running(running),
    .rst_req(wdg_rst_req)
  );

  AST_LOCK_DIV: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(pr_q)); // R5
  AST_LOCK_RELOAD: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(rl_q)); // R5
  AST_BUSY_HOLD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    xbusy[XF_RELOAD] |=> $stable(rl_q)); // R8
  AST_BUSY_HOLD_DIV: assert property (@(posedge clk) disable iff (rst)
    xbusy[XF_DIV] |=> $stable(pr_q)); // R8
endmodule

// File: tb/wdg_timer_tb_top.sv
module wdg_timer_tb_top;
  logic        clk = 1'b0, slow_clk = 1'b0;
  logic        rst = 1'b1, slow_rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0, rd_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dbg_halt = 1'b0, dbg_freeze = 1'b0;
  logic        wdg_rst_req;

  always #10 clk = ~clk;        // 50 MHz
  always #40 slow_clk = ~slow_clk;

  wdg_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .slow_clk(slow_clk), .slow_rst(slow_rst),
    .dbg_halt(dbg_halt), .dbg_freeze(dbg_freeze), .wdg_rst_req(wdg_rst_req)
  );

  int total = 0, bad = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reset-request monitor in the slow domain
  int scnt = 0, rises = 0, last_rise = 0, last_period = 0, rise_at = 0, last_width = 0;
  logic prev_req = 1'b0;
  always @(negedge slow_clk) begin
    if (!slow_rst) begin
      scnt = scnt + 1;
      if (wdg_rst_req && !prev_req) begin
        rises       = rises + 1;
        last_period = scnt - last_rise;
        last_rise   = scnt;
        rise_at     = scnt;
      end
      if (!wdg_rst_req && prev_req) last_width = scnt - rise_at;
      prev_req = wdg_rst_req;
    end
  end

  task automatic bus_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(negedge slow_clk);
  endtask

  task automatic wait_rises(input int n, input string tag);
    int target = rises + n;
    int guard = 0;
    while (rises < target && guard < 3000) begin
      @(negedge slow_clk);
      guard++;
    end
    check({tag, " request seen"}, rises >= target, 1);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] d = 32'h1;
    for (int i = 0; i < 100 && d != 0; i++) bus_rd(2'd3, d);
    check(tag, d, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(2'd1, d); check("R1 divider reset", d, 0);
    bus_rd(2'd2, d); check("R1 reload reset", d, 32'hFFF);
    bus_rd(2'd3, d); check("R1 status reset", d, 0);
    bus_rd(2'd0, d); check("R10 key reads zero", d, 0);
    check("R1 request low", wdg_rst_req, 0);
    wait_slow(200);
    check("R1 no request before start", rises, 0);
  endtask

  task automatic t_locked();
    logic [31:0] d;
    bus_wr(2'd2, 32'd3);
    bus_rd(2'd2, d); check("R5 locked reload write ignored", d, 32'hFFF);
    bus_rd(2'd3, d); check("R5 locked write starts no transfer", d, 0);
  endtask

  task automatic t_unlock_busy();
    logic [31:0] d;
    bus_wr(2'd0, 32'hFFFF_5555);           // upper half ignored
    bus_wr(2'd1, 32'd0);
    bus_rd(2'd3, d); check("R7 divider busy bit0", d, 1);
    wait_idle("R7 divider busy clears");
    bus_wr(2'd2, 32'd3);
    bus_wr(2'd2, 32'd5);                   // lands while busy
    bus_rd(2'd3, d); check("R7 reload busy bit1", d, 2);
    wait_idle("R7 reload busy clears");
    bus_rd(2'd2, d); check("R8 write during busy dropped", d, 3);
    bus_rd(2'd2, d); check("R5 upper key bits ignored on unlock", d, 3);
  endtask

  task automatic t_relock();
    logic [31:0] d;
    bus_wr(2'd0, 32'h0000_AAAA);
    bus_wr(2'd2, 32'd9);
    bus_rd(2'd2, d); check("R5 refresh key relocks", d, 3);
  endtask

  task automatic t_start();
    bus_wr(2'd0, 32'h0000_CCCC);
    wait_rises(3, "R2");
    check("R2 period div4 rl3", last_period, 16);
    check("R3 request width", last_width, 4);
  endtask

  task automatic t_nostop();
    bus_wr(2'd0, 32'h0000_0000);
    bus_wr(2'd0, 32'h0000_1234);
    wait_rises(2, "R2 after foreign keys");
    check("R2 still running after foreign keys", last_period, 16);
  endtask

  task automatic t_refresh();
    int r0;
    wait_rises(1, "R4 pre");
    r0 = rises;
    for (int i = 0; i < 40; i++) begin
      bus_wr(2'd0, 32'h0000_AAAA);
      wait_slow(6);
    end
    check("R4 refresh suppresses request", rises, r0);
    wait_rises(1, "R4 expiry after refresh stops");
  endtask

  task automatic t_div(input int p);
    int dv;
    dv = 4 << ((p > 6) ? 6 : p);
    bus_wr(2'd0, 32'h0000_5555);
    bus_wr(2'd2, 32'd1);
    wait_idle("R7 reload idle");
    bus_wr(2'd1, p);
    wait_idle("R7 divider idle");
    wait_rises(3, "R6");
    check($sformatf("R6 period select %0d", p), last_period, 2 * dv);
  endtask

  task automatic t_freeze();
    bus_wr(2'd0, 32'h0000_5555);
    bus_wr(2'd2, 32'd15);
    wait_idle("R7 reload idle");
    bus_wr(2'd1, 32'd0);
    wait_idle("R7 divider idle");
    wait_rises(2, "R9 base");
    check("R9 base period", last_period, 64);
    wait_slow(10);
    dbg_halt = 1'b1; dbg_freeze = 1'b1;
    wait_slow(20);
    dbg_halt = 1'b0; dbg_freeze = 1'b0;
    wait_rises(1, "R9 frozen");
    check("R9 freeze stretches period", last_period, 84);
    wait_rises(1, "R9 settle");
    wait_slow(10);
    dbg_halt = 1'b1;
    wait_slow(20);
    dbg_halt = 1'b0;
    wait_rises(1, "R9 halt only");
    check("R9 halt without freeze bit", last_period, 64);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge slow_clk);
    rst = 1'b0;
    slow_rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_locked();
    t_unlock_busy();
    t_relock();
    t_start();
    t_nostop();
    t_refresh();
    t_div(1);
    t_div(3);
    t_div(6);
    t_div(7);
    t_freeze();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule